// File: doc/BRIEF.md
# Hierarchical Boosted Lookup-Table Binary Neuron

This block produces one binary neuron decision from a 216-bit binary feature vector. It does not multiply and accumulate over every input. The input is cut into 36 slices of 6 bits, and each slice addresses a 64-entry by 1-bit truth table, called a leaf. The leaves sit in six groups of six. Each group adds a signed weight for every leaf that fires and compares that sum with its own signed threshold. A second stage of the same kind then combines the six group decisions into the final bit.

All table bits, weights and thresholds come in through a single write port. Writes are accepted only while the datapath is idle. Features enter with a valid strobe, and the decision leaves with its own valid strobe after a fixed three-cycle latency. One build-time parameter chooses how each weighted-threshold stage is built: either as explicit adders, or as a 64-entry decision table derived from the current weights. Both forms give the same results.

Top module: `boosted_lut_neuron`

## Requirements
- R1: Leaf j (0 to 35) reads `in_vec[6j+5:6j]` as its table address, with `in_vec[6j]` as the address LSB. Its output is the stored bit at that address.
- R2: Group g (0 to 5) combines leaves 6g to 6g+5. Leaf 6g+k contributes group weight k when its bit is 1. The group outputs 1 exactly when the signed sum is greater than or equal to the group's signed threshold.
- R3: `out_bit` is 1 exactly when the signed sum of top weight g over every group g that output 1 is greater than or equal to the signed top threshold.
- R4: `out_valid` is high exactly 3 cycles after a cycle with `in_valid` high, and at no other time. Back-to-back inputs stream one per cycle. `out_bit` holds its value whenever `out_valid` is low.
- R5: The write port is encoded by `cfg_sel`, and `cfg_data` is the payload:
  - `cfg_sel`=0 writes leaf table bit `cfg_data[0]`, with `cfg_addr[11:6]` as the leaf and `cfg_addr[5:0]` as the entry.
  - `cfg_sel`=1 writes group weight k of group g at `cfg_addr` = 6g+k.
  - `cfg_sel`=2 writes the threshold of group g at `cfg_addr` = g.
  - `cfg_sel`=3 writes top weight g at `cfg_addr` 0 to 5, and the top threshold at `cfg_addr` 6.
  - Writes to other addresses change nothing.
- R6: A write is ignored in any cycle where `in_valid` is high, or where an input taken in either of the two previous cycles is still in flight. An accepted write affects every input taken after it.
- R7: Reset clears every table bit, weight and threshold to zero, and clears `out_valid` and `out_bit`. The first input after reset therefore yields 1, because every sum is 0 and 0 is not below a zero threshold.
- R8: The table-based stage variant gives the same `out_bit` as the adder-based variant for every input and every configuration.
- R9: Weights and thresholds are 8-bit two's complement. Sums are kept at 11 bits, so six weights of -128 give -768 and six weights of 127 give 762, with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Feature vector valid |
| in_vec | input | 216 | Binary feature vector |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Selects the kind of configuration target |
| cfg_addr | input | 12 | Configuration target index |
| cfg_data | input | 8 | Configuration payload |
| out_valid | output | 1 | Decision valid |
| out_bit | output | 1 | Binary neuron decision |

## Verification
On every cycle the assertions check four things: the exact three-cycle latency of the valid strobe, that the decision holds between valid results, that a top-threshold write is blocked while inputs are in flight, and that an accepted top-threshold write lands with the written value. The following can only be shown by the bench's scenarios, which compare results against an independent model of the two-level vote:
- the leaf slice addressing
- the signed group and top sums, including the extreme sums that would wrap at 8 bits
- the match between the table and adder variants
- the effect of reset on stored contents

// File: rtl/bln_pkg.sv
package bln_pkg;
  // configuration target kinds (value of cfg_sel)
  localparam logic [1:0] SEL_LEAF = 2'd0;
  localparam logic [1:0] SEL_GW   = 2'd1;
  localparam logic [1:0] SEL_GT   = 2'd2;
  localparam logic [1:0] SEL_TOP  = 2'd3;
endpackage

// File: rtl/bln_leaf_bank.sv
module bln_leaf_bank #(
  parameter int FAN   = 6,
  parameter int NLEAF = 36,
  parameter int AW    = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [NLEAF*FAN-1:0] x,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic                 wr_bit,
  output logic [NLEAF-1:0]     leaf_q
);
  localparam int DEPTH = 1 << FAN;

  for (genvar j = 0; j < NLEAF; j++) begin : g_leaf
    logic [DEPTH-1:0] tbl;
    logic             q;

    // R1: per-leaf truth table, written one bit at a time
    always_ff @(posedge clk) begin
      if (rst) begin
        tbl <= '0;
      end else if (wr_en && wr_addr[AW-1:FAN] == (AW-FAN)'(j)) begin
        tbl[wr_addr[FAN-1:0]] <= wr_bit;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= 1'b0;
      end else if (en) begin
        q <= tbl[x[j*FAN +: FAN]];
      end
    end

    assign leaf_q[j] = q;
  end
endmodule

// File: rtl/bln_vote.sv
module bln_vote #(
  parameter int N       = 6,
  parameter int WW      = 8,
  parameter int SW      = 11,
  parameter bit PRECOMP = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [N-1:0]         bits_in,
  input  logic signed [WW-1:0] w [N],
  input  logic signed [WW-1:0] thr,
  output logic                 q
);
  logic d;

  if (PRECOMP) begin : g_tab
    // R8: evaluate every input pattern, then index by the live bits
    localparam int P = 1 << N;
    logic [P-1:0]         tab;
    logic signed [SW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int p = 0; p < P; p++) begin
        acc = '0;
        for (int k = 0; k < N; k++) begin
          if (p[k]) acc = acc + SW'(w[k]);
        end
        tab[p] = (acc >= SW'(thr));
      end
    end
    assign d = tab[bits_in];
  end else begin : g_add
    // R2/R3/R9: signed accumulation at full sum width
    logic signed [SW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int k = 0; k < N; k++) begin
        if (bits_in[k]) acc = acc + SW'(w[k]);
      end
    end
    assign d = (acc >= SW'(thr));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/boosted_lut_neuron.sv
module boosted_lut_neuron
  import bln_pkg::*;
#(
  parameter int FAN     = 6,
  parameter int WW      = 8,
  parameter int SW      = 11,
  parameter int AW      = 12,
  parameter bit PRECOMP = 1'b0,
  localparam int NG     = FAN,
  localparam int NLEAF  = FAN * FAN,
  localparam int NIN    = NLEAF * FAN
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [NIN-1:0] in_vec,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [WW-1:0]  cfg_data,
  output logic           out_valid,
  output logic           out_bit
);
  logic v1, v2;
  logic busy, wr_ok;
  logic [NLEAF-1:0] leaf_q;
  logic [NG-1:0]    grp_q;

  logic signed [WW-1:0] w1_q [NG][FAN];
  logic signed [WW-1:0] t1_q [NG];
  logic signed [WW-1:0] w2_q [NG];
  logic signed [WW-1:0] t2_q;

  // R6: configuration only while nothing is in flight
  assign busy  = in_valid | v1 | v2;
  assign wr_ok = cfg_we & ~busy;

  // R4: valid pipeline, one register per stage
  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      out_valid <= v2;
    end
  end

  // R5/R7: weight and threshold storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NG; g++) begin
        for (int k = 0; k < FAN; k++) w1_q[g][k] <= '0;
        t1_q[g] <= '0;
        w2_q[g] <= '0;
      end
      t2_q <= '0;
    end else if (wr_ok) begin
      case (cfg_sel)
        SEL_GW: begin
          for (int g = 0; g < NG; g++)
            for (int k = 0; k < FAN; k++)
              if (cfg_addr == AW'(g*FAN+k)) w1_q[g][k] <= cfg_data;
        end
        SEL_GT: begin
          for (int g = 0; g < NG; g++)
            if (cfg_addr == AW'(g)) t1_q[g] <= cfg_data;
        end
        SEL_TOP: begin
          for (int g = 0; g < NG; g++)
            if (cfg_addr == AW'(g)) w2_q[g] <= cfg_data;
          if (cfg_addr == AW'(NG)) t2_q <= cfg_data;
        end
        default: ;
      endcase
    end
  end

  bln_leaf_bank #(.FAN(FAN), .NLEAF(NLEAF), .AW(AW)) u_leaves (
    .clk     (clk),
    .rst     (rst),
    .en      (in_valid),
    .x       (in_vec),
    .wr_en   (wr_ok && cfg_sel == SEL_LEAF),
    .wr_addr (cfg_addr),
    .wr_bit  (cfg_data[0]),
    .leaf_q  (leaf_q)
  );

  for (genvar g = 0; g < NG; g++) begin : g_grp
    bln_vote #(.N(FAN), .WW(WW), .SW(SW), .PRECOMP(PRECOMP)) u_grp (
      .clk     (clk),
      .rst     (rst),
      .en      (v1),
      .bits_in (leaf_q[g*FAN +: FAN]),
      .w       (w1_q[g]),
      .thr     (t1_q[g]),
      .q       (grp_q[g])
    );
  end

  bln_vote #(.N(NG), .WW(WW), .SW(SW), .PRECOMP(PRECOMP)) u_top (
    .clk     (clk),
    .rst     (rst),
    .en      (v2),
    .bits_in (grp_q),
    .w       (w2_q),
    .thr     (t2_q),
    .q       (out_bit)
  );
endmodule

// File: rtl/bln_checker.sv
module bln_checker #(
  parameter int FAN = 6,
  parameter int WW  = 8,
  parameter int AW  = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic [AW-1:0] cfg_addr,
  input logic [WW-1:0] cfg_data,
  input logic          out_valid,
  input logic          out_bit,
  input logic          v1,
  input logic          v2,
  input logic [WW-1:0] t2_q
);
  logic [1:0] since;
  always_ff @(posedge clk) begin
    if (rst) since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_bit));

  assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (in_valid || v1 || v2)) |=> $stable(t2_q));

  assert_top_thr_write_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !in_valid && !v1 && !v2 && cfg_sel == 2'd3 && cfg_addr == AW'(FAN))
    |=> (t2_q == $past(cfg_data)));
endmodule

bind boosted_lut_neuron bln_checker #(.FAN(FAN), .WW(WW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_addr  (cfg_addr),
  .cfg_data  (cfg_data),
  .out_valid (out_valid),
  .out_bit   (out_bit),
  .v1        (v1),
  .v2        (v2),
  .t2_q      (t2_q)
);

// File: tb/sim_boosted_lut_neuron.sv
`timescale 1ns/1ps
module sim_boosted_lut_neuron;
  localparam int FAN = 6, NLEAF = 36, NIN = 216, WW = 8, AW = 12;

  localparam logic [NIN-1:0] STIM [8] = '{
    '0, '1,
    {54{4'hA}}, {54{4'h5}},
    {27{8'hC3}}, {18{12'h9F1}},
    {8{27'h5A3C1E7}}, {24{9'h1B5}}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic           in_valid = 1'b0;
  logic [NIN-1:0] in_vec = '0;
  logic           cfg_we = 1'b0;
  logic [1:0]     cfg_sel = '0;
  logic [AW-1:0]  cfg_addr = '0;
  logic [WW-1:0]  cfg_data = '0;
  logic ov0, ob0, ov1, ob1;

  boosted_lut_neuron #(.PRECOMP(1'b0)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .out_valid(ov0), .out_bit(ob0));

  boosted_lut_neuron #(.PRECOMP(1'b1)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .out_valid(ov1), .out_bit(ob1));

  int checks = 0;
  int errors = 0;

  // shadow configuration for the reference model
  logic [63:0] s_tbl [NLEAF];
  int s_w1 [6][6];
  int s_t1 [6];
  int s_w2 [6];
  int s_t2;

  function automatic void clear_shadow();
    for (int j = 0; j < NLEAF; j++) s_tbl[j] = '0;
    for (int g = 0; g < 6; g++) begin
      for (int k = 0; k < 6; k++) s_w1[g][k] = 0;
      s_t1[g] = 0;
      s_w2[g] = 0;
    end
    s_t2 = 0;
  endfunction

  function automatic logic model(input logic [NIN-1:0] x);
    int top, gsum;
    top = 0;
    for (int g = 0; g < 6; g++) begin
      gsum = 0;
      for (int k = 0; k < 6; k++) begin
        if (s_tbl[g*6+k][x[(g*6+k)*6 +: 6]]) gsum += s_w1[g][k];
      end
      if (gsum >= s_t1[g]) top += s_w2[g];
    end
    return (top >= s_t2);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clear_shadow();
    chk("R7 out_valid after reset", ov0, 1'b0);
    chk("R7 out_bit after reset", ob0, 1'b0);
  endtask

  task automatic cfg(input logic [1:0] sel, input int addr, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sel = sel;
    cfg_addr = AW'(addr);
    cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: if (addr < NLEAF*64) s_tbl[addr/64][addr%64] = d[0];
      2'd1: if (addr < 36) s_w1[addr/6][addr%6] = int'($signed(d));
      2'd2: if (addr < 6) s_t1[addr] = int'($signed(d));
      default: begin
        if (addr < 6) s_w2[addr] = int'($signed(d));
        else if (addr == 6) s_t2 = int'($signed(d));
      end
    endcase
  endtask

  // one isolated input, checked on the exact output cycle
  task automatic run1(input logic [NIN-1:0] x, input string tag);
    logic e;
    e = model(x);
    @(negedge clk);
    in_valid = 1'b1;
    in_vec = x;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk({tag, " R4 not yet valid"}, ov0, 1'b0);
    @(negedge clk);
    chk({tag, " R4 valid"}, ov0, 1'b1);
    chk({tag, " result"}, ob0, e);
    chk({tag, " R8 table variant"}, ob1, e);
    @(negedge clk);
    chk({tag, " R4 single pulse"}, ov0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NIN-1:0] x;
    logic ex [3];

    // R7: reset state and cleared contents
    do_reset();
    run1(STIM[6], "R7 cleared contents give 1");
    chk("R7 explicit value", ob0, 1'b1);

    // R1: only leaf 7 (bits 47:42), entry 45, routes through
    cfg(2'd0, 7*64 + 45, 8'h01);
    cfg(2'd1, 7, 8'h01);
    cfg(2'd2, 1, 8'h01);
    cfg(2'd3, 1, 8'h01);
    cfg(2'd3, 6, 8'h01);
    x = '0; x[47:42] = 6'd45;
    run1(x, "R1 leaf7 hit");
    chk("R1 leaf7 hit value", ob0, 1'b1);
    x[47:42] = 6'd44;
    run1(x, "R1 leaf7 miss");
    chk("R1 leaf7 miss value", ob0, 1'b0);
    x = '0; x[41:36] = 6'd45;
    run1(x, "R1 neighbour leaf6 slice");
    cfg(2'd2, 9, 8'h7F);  // R5: nonexistent group threshold
    x = '0; x[47:42] = 6'd45;
    run1(x, "R5 out-of-range write ignored");

    // R6: writes during activity are dropped
    do_reset();
    @(negedge clk);
    in_valid = 1'b1; in_vec = STIM[2];
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_addr = 12'd6; cfg_data = 8'h01;
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 write with in_valid, valid", ov0, 1'b1);
    chk("R6 write with in_valid, result", ob0, 1'b1);
    @(negedge clk);
    in_valid = 1'b1; in_vec = STIM[3];
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_addr = 12'd6; cfg_data = 8'h01;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    chk("R6 write in flight, result", ob0, 1'b1);
    run1(STIM[4], "R6 threshold unchanged");
    chk("R6 threshold unchanged value", ob0, 1'b1);
    cfg(2'd3, 6, 8'h01);
    run1(STIM[4], "R6 idle write accepted");
    chk("R6 idle write value", ob0, 1'b0);

    // R9: extreme signed sums
    do_reset();
    for (int g = 0; g < 6; g++) cfg(2'd3, g, 8'h80);
    cfg(2'd3, 6, 8'h80);
    run1(STIM[0], "R9 sum -768 vs -128");
    chk("R9 negative extreme", ob0, 1'b0);
    for (int g = 0; g < 6; g++) cfg(2'd3, g, 8'h7F);
    cfg(2'd3, 6, 8'h7F);
    run1(STIM[0], "R9 sum 762 vs 127");
    chk("R9 positive extreme", ob0, 1'b1);

    // R2/R3: full configuration, table-driven vectors
    do_reset();
    for (int j = 0; j < NLEAF; j++)
      for (int e = 0; e < 64; e++)
        cfg(2'd0, j*64 + e, {7'd0, ((j*37 + e*11 + (e/8)*5) % 7) < 3});
    for (int a = 0; a < 36; a++) cfg(2'd1, a, 8'(((a*29) % 61) - 30));
    for (int g = 0; g < 6; g++) cfg(2'd2, g, 8'(g*7 - 10));
    cfg(2'd3, 0, 8'd40);
    cfg(2'd3, 1, 8'(-25));
    cfg(2'd3, 2, 8'd33);
    cfg(2'd3, 3, 8'(-60));
    cfg(2'd3, 4, 8'd18);
    cfg(2'd3, 5, 8'd27);
    cfg(2'd3, 6, 8'd5);
    for (int i = 0; i < 8; i++) run1(STIM[i], "R2 R3 vector");

    // R4: back-to-back streaming
    for (int i = 0; i < 3; i++) ex[i] = model(STIM[i+3]);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        chk("R4 stream valid", ov0, 1'b1);
        chk("R4 stream result", ob0, ex[i-3]);
        chk("R8 stream table variant", ob1, ex[i-3]);
      end
      if (i < 3) begin
        in_valid = 1'b1;
        in_vec = STIM[i+3];
      end else begin
        in_valid = 1'b0;
      end
    end

    // R7: reset after a loaded configuration wipes it
    do_reset();
    run1(STIM[5], "R7 reset wipes configuration");
    chk("R7 wiped value", ob0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule